// File: doc/BRIEF.md
# Prioritized Transmit Queue Selector

This block decides which of several transmit queues hands its frame to the MAC transmitter next. Every queue has a pending request. When the transmitter reports that it is idle and can accept a new frame, the selector grants the pending queue with the smallest index. It raises a one-cycle start pulse with that index, then holds the grant until the transmitter returns a frame-done strobe.

Most queues are ordinary. A host commit pulse on such a queue raises its request, and the request drops when its frame completes. Two queues are static. A host commit on a static queue does not request a send. It only marks that queue's stored frame as loaded, and the frame stays loaded after each transmission. Queue 2 is then sent on each rising edge of the main-buffer watermark indication, which suits pause frames. Queue 5 is sent on each rising edge of the host-interrupt timeout indication, which suits host-not-responding frames. A static queue ignores its trigger until it has been loaded.

Top module: `txq_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `start` and `busy` are 0, `grant_idx` is 0 and no queue is pending.
- R2: `start` is high for exactly one cycle. It rises on the cycle after an edge at which the selector was idle, `tx_ready` was 1 and at least one request was pending. `busy` rises together with `start`.
- R3: Among the pending queues, the granted index is always the lowest one.
- R4: From `start` until the edge that samples `frame_done`, `grant_idx` stays constant and `busy` stays 1. On the cycle after that edge `busy` is 0.
- R5: A `host_commit[i]` pulse on a non-static queue i makes that queue pending. The granted queue's request is cleared when `frame_done` is sampled, and other pending requests are left as they are.
- R6: A loaded static queue stays loaded after it has been sent, so each later trigger sends it again with no new commit.
- R7: Static queue 2 becomes pending on each 0-to-1 transition of `wm_cross`. Holding `wm_cross` high sends only one frame.
- R8: Static queue 5 becomes pending on each 0-to-1 transition of `host_timeout`.
- R9: A static queue whose frame has never been loaded through `host_commit` ignores its trigger.
- R10: A request that arrives while a frame is in flight does not change the grant. It is served by the next arbitration.
- R11: `frame_done` while idle has no effect, and no start happens while `tx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ready | input | 1 | Transmitter is idle and can take a new frame |
| frame_done | input | 1 | Transmitter finished the granted frame |
| host_commit | input | NUM_Q | Per-queue pulse: commit a frame on ordinary queues, load the stored frame on static queues |
| wm_cross | input | 1 | Main-buffer watermark indication (level) |
| host_timeout | input | 1 | Host-interrupt timeout indication (level) |
| start | output | 1 | One-cycle pulse that starts the granted frame |
| busy | output | 1 | A granted frame is in flight |
| grant_idx | output | IW | Index of the granted queue |

## Verification
The assertions assume that `frame_done` matters only while `busy` is high. They also assume the transmitter does not end a frame before it has been started. The stimulus therefore pulses `frame_done` only after it has seen the start pulse, apart from one deliberate pulse while idle that checks it is ignored. Commits and trigger edges are driven at any time, including while a frame is in flight, so that held requests and same-cycle competing requests reach the priority logic.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

    // index of the least significant set bit, 0 when none is set
    function automatic int unsigned lowest_set(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/txq_static_arm.sv
module txq_static_arm (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic load,
    output logic fire
);
    logic trig_prev;
    logic loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_prev <= 1'b0;
            loaded    <= 1'b0;
        end else begin
            trig_prev <= trig;
            if (load) loaded <= 1'b1;
        end
    end

    assign fire = loaded & trig & ~trig_prev;
endmodule

// File: rtl/txq_req_bank.sv
module txq_req_bank #(
    parameter int NUM_Q = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_Q-1:0] set_v,
    input  logic [NUM_Q-1:0] clr_v,
    output logic [NUM_Q-1:0] req_q
);
    // a new request in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= set_v | (req_q & ~clr_v);
    end
endmodule

// File: rtl/txq_pick.sv
module txq_pick import txq_pkg::*; #(
    parameter int NUM_Q = 6,
    parameter int IW    = 3
) (
    input  logic [NUM_Q-1:0] req,
    output logic [IW-1:0]    idx,
    output logic             any
);
    logic [31:0] wide;
    assign wide = 32'(req);
    assign idx  = IW'(lowest_set(wide));
    assign any  = |req;
endmodule

// File: rtl/txq_arbiter.sv
module txq_arbiter import txq_pkg::*; #(
    parameter int NUM_Q = 6,
    parameter int WM_Q  = 2,
    parameter int TO_Q  = 5,
    localparam int IW   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_ready,
    input  logic             frame_done,
    input  logic [NUM_Q-1:0] host_commit,
    input  logic             wm_cross,
    input  logic             host_timeout,
    output logic             start,
    output logic             busy,
    output logic [IW-1:0]    grant_idx
);
    arb_state_e       state_q;
    logic [IW-1:0]    grant_q;
    logic             start_q;
    logic [NUM_Q-1:0] set_v;
    logic [NUM_Q-1:0] clr_v;
    logic [NUM_Q-1:0] req_q;
    logic [IW-1:0]    pick_idx;
    logic             pick_any;
    logic             launch;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        if (q == WM_Q || q == TO_Q) begin : g_static
            txq_static_arm u_arm (
                .clk  (clk),
                .rst  (rst),
                .trig ((q == WM_Q) ? wm_cross : host_timeout),
                .load (host_commit[q]),
                .fire (set_v[q])
            );
        end else begin : g_plain
            assign set_v[q] = host_commit[q];
        end
        assign clr_v[q] = (state_q == ARB_BUSY) && frame_done && (grant_q == IW'(q));
    end

    txq_req_bank #(.NUM_Q(NUM_Q)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .req_q (req_q)
    );

    txq_pick #(.NUM_Q(NUM_Q), .IW(IW)) u_pick (
        .req (req_q),
        .idx (pick_idx),
        .any (pick_any)
    );

    assign launch = (state_q == ARB_IDLE) && tx_ready && pick_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= launch;
            if (launch) begin
                state_q <= ARB_BUSY;
                grant_q <= pick_idx;
            end else if (state_q == ARB_BUSY && frame_done) begin
                state_q <= ARB_IDLE;
            end
        end
    end

    assign start     = start_q;
    assign busy      = (state_q == ARB_BUSY);
    assign grant_idx = grant_q;
endmodule

// File: rtl/txq_arbiter_chk.sv
module txq_arbiter_chk #(
    parameter int NUM_Q = 6,
    parameter int IW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_ready,
    input logic             frame_done,
    input logic             start,
    input logic             busy,
    input logic [IW-1:0]    grant_idx,
    input logic [NUM_Q-1:0] req_q
);
    logic [NUM_Q-1:0] req_prev;
    logic [NUM_Q-1:0] below;

    always_ff @(posedge clk) begin
        if (rst) req_prev <= '0;
        else     req_prev <= req_q;
    end

    always_comb begin
        for (int i = 0; i < NUM_Q; i++) below[i] = (i < int'(grant_idx));
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !start && req_q == '0));

    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        start |-> busy);

    assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (rst)
        start |-> (req_prev[grant_idx] && (req_prev & below) == '0));

    assert_grant_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_done) |=> (busy && $stable(grant_idx)));

    assert_done_release_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && frame_done) |=> !busy);

    assert_no_start_unready_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !tx_ready) |=> !start);
endmodule

bind txq_arbiter txq_arbiter_chk #(.NUM_Q(NUM_Q), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_ready   (tx_ready),
    .frame_done (frame_done),
    .start      (start),
    .busy       (busy),
    .grant_idx  (grant_idx),
    .req_q      (req_q)
);

// File: tb/txq_arbiter_bench.sv
module txq_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 6;

    logic clk = 0;
    logic rst = 1;
    logic tx_ready = 0;
    logic frame_done = 0;
    logic [NQ-1:0] host_commit = '0;
    logic wm_cross = 0;
    logic host_timeout = 0;
    logic start, busy;
    logic [2:0] grant_idx;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // behavioural reference
    bit m_req [NQ];
    bit m_loaded [NQ];
    bit m_busy, m_start, m_wm_prev, m_to_prev;
    int m_grant;

    txq_arbiter u_txq_arbiter (
        .clk(clk), .rst(rst), .tx_ready(tx_ready), .frame_done(frame_done),
        .host_commit(host_commit), .wm_cross(wm_cross), .host_timeout(host_timeout),
        .start(start), .busy(busy), .grant_idx(grant_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_req[i]) begin m_req[i] = 0; m_loaded[i] = 0; end
            m_busy = 0; m_start = 0; m_grant = 0; m_wm_prev = 0; m_to_prev = 0;
        end else begin
            int pick;
            bit any;
            bit nxt [NQ];
            pick = -1;
            for (int i = NQ - 1; i >= 0; i--) if (m_req[i]) pick = i;
            any = (pick >= 0);
            for (int i = 0; i < NQ; i++) begin
                bit s, c;
                if (i == 2)      s = m_loaded[i] && wm_cross && !m_wm_prev;
                else if (i == 5) s = m_loaded[i] && host_timeout && !m_to_prev;
                else             s = host_commit[i];
                c = m_busy && frame_done && (m_grant == i);
                nxt[i] = s || (m_req[i] && !c);
            end
            if (host_commit[2]) m_loaded[2] = 1;
            if (host_commit[5]) m_loaded[5] = 1;
            m_wm_prev = wm_cross;
            m_to_prev = host_timeout;
            foreach (m_req[i]) m_req[i] = nxt[i];
            if (!m_busy && tx_ready && any) begin
                m_start = 1; m_busy = 1; m_grant = pick;
            end else begin
                m_start = 0;
                if (m_busy && frame_done) m_busy = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check({phase, " start"}, int'(start), int'(m_start));
            check({phase, " busy"},  int'(busy),  int'(m_busy));
            check({phase, " grant"}, int'(grant_idx), m_grant);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic commit(input int q);
        host_commit[q] = 1'b1;
        cyc(1);
        host_commit = '0;
    endtask

    // wait for a start, check its index, then end the frame
    task automatic serve(input int exp, input string tag);
        int n;
        n = 0;
        while (!start && n < 20) begin cyc(1); n++; end
        check({tag, " granted queue"}, int'(grant_idx), exp);
        cyc(2);
        frame_done = 1'b1;
        cyc(1);
        frame_done = 1'b0;
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen;
        seen = 0;
        repeat (n) begin cyc(1); if (start) seen++; end
        check({tag, " no start"}, seen, 0);
    endtask

    initial begin
        cyc(3);
        check("R1 reset start", int'(start), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset grant", int'(grant_idx), 0);
        rst = 0;
        cyc(2);

        phase = "R11";
        commit(3);
        frame_done = 1; cyc(1); frame_done = 0;
        expect_quiet(4, "R11");
        tx_ready = 1;
        serve(3, "R11");

        phase = "R3";
        tx_ready = 0;
        host_commit = 6'b011010; cyc(1); host_commit = '0;
        tx_ready = 1;
        serve(1, "R3");
        serve(3, "R5");
        phase = "R10";
        begin
            int n;
            n = 0;
            while (!start && n < 20) begin cyc(1); n++; end
            check("R10 in-flight queue", int'(grant_idx), 4);
        end
        commit(0);
        cyc(2);
        check("R10 grant held", int'(grant_idx), 4);
        frame_done = 1; cyc(1); frame_done = 0;
        serve(0, "R10");

        phase = "R9";
        wm_cross = 1; cyc(1); wm_cross = 0;
        host_timeout = 1; cyc(1); host_timeout = 0;
        expect_quiet(5, "R9");

        commit(2);
        commit(5);
        expect_quiet(3, "R9 load only");

        phase = "R7";
        wm_cross = 1;
        serve(2, "R7");
        expect_quiet(6, "R7 level held");
        wm_cross = 0; cyc(1);
        phase = "R6";
        wm_cross = 1;
        serve(2, "R6");
        wm_cross = 0;

        phase = "R8";
        host_timeout = 1;
        serve(5, "R8");
        host_timeout = 0; cyc(1);

        phase = "R3";
        tx_ready = 0;
        wm_cross = 1; host_timeout = 1; host_commit[0] = 1; cyc(1);
        host_commit = '0; wm_cross = 0; host_timeout = 0;
        tx_ready = 1;
        serve(0, "R3");
        serve(2, "R3");
        serve(5, "R6");
        expect_quiet(4, "R5");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule